// File: doc/BRIEF.md
# NOR Flash Block Erase-and-Program Sequencer

This block rewrites one logical block of a 16-bit NOR flash that uses unlock-cycle command sequences. One start pulse makes it erase every physical sector that the block covers and then program the block one word at a time. The words come from a local buffer. The sequencer works out each erase step from the device code and the sector geometry supplied at its ports. The same region can be made of small subsectors on one device and of full sectors on another.

Completion is found by reading the flash back. An erased sector reads as all ones. A programmed word reads as the value just written. Each poll waits a programmable gap before it reads, and a programmable limit on the number of reads bounds the wait. A single-cycle done pulse reports the result together with a 2-bit status code. The caller keeps the geometry, gap and limit ports stable while an operation runs.

Top module: `fss_flash_seq`

## Requirements
- R1: After reset, done is 0, status is 0 and neither fl_we nor fl_re is asserted.
- R2: A start whose dev_code matches none of the configured device codes writes nothing to the flash. It raises done in the cycle after the start edge, with status 2 (unknown device).
- R3: Each sector erase is exactly six flash writes, one per cycle, at byte addresses and data as follows: 0x00AA at 0xAAA, 0x0055 at 0x554, 0x0080 at 0xAAA, 0x00AA at 0xAAA, 0x0055 at 0x554, then 0x0030 at the sector's byte address.
- R4: The first erase targets blk_off. Each following erase advances by sub_size when (address AND sub_mask) equals the subsector base of the selected device, and by sect_size otherwise. Erasing stops once the next address reaches blk_off + blk_size. The defaults give device 0x2249 base 0x000000 and device 0x22C4 base 0x1F0000.
- R5: After an erase command, the sector address is read until it returns 0xFFFF, with at most erase_limit reads. If the limit runs out, status becomes 1, no program write is issued, and done follows.
- R6: Two successive reads of one poll are exactly gap + 3 cycles apart. The gap is erase_gap while erasing and prog_gap while programming.
- R7: Each word at byte address A is programmed with four writes: 0x00AA at 0xAAA, 0x0055 at 0x554, 0x00A0 at 0xAAA, then the buffer word at A. The buffer word comes from buffer index (A − blk_off)/2. The buffer returns data in the cycle after buf_rd, and no flash write happens in that cycle.
- R8: After each program command, A is read until the readback equals the word, with at most prog_limit reads. A timeout ends the operation at once with status 1. Otherwise A advances by 2 until blk_off + blk_size.
- R9: done is high for exactly one cycle per operation, with no flash strobe in that cycle. A completed operation reports status 0. A zero blk_size completes with status 0 and no flash access.
- R10: A start pulse that arrives while an operation is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| blk_off | input | AW | Byte offset of the block |
| blk_size | input | AW | Block length in bytes |
| dev_code | input | 16 | Device code of the attached flash |
| sect_size | input | AW | Normal sector size in bytes |
| sub_size | input | AW | Subsector size in bytes |
| sub_mask | input | AW | Mask applied to an address for the subsector test |
| erase_gap | input | CW | Wait cycles before each erase poll read |
| erase_limit | input | CW | Maximum erase poll reads |
| prog_gap | input | CW | Wait cycles before each program poll read |
| prog_limit | input | CW | Maximum program poll reads |
| buf_rd | output | 1 | Buffer read strobe |
| buf_addr | output | AW-1 | Buffer word index |
| buf_rdata | input | 16 | Buffer word, valid the cycle after buf_rd |
| fl_addr | output | AW | Flash byte address |
| fl_wdata | output | 16 | Flash write data |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_rdata | input | 16 | Flash read data, valid the cycle after fl_re |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 success, 1 timeout, 2 unknown device |

## Verification
For an unknown device, done is due one cycle after the start edge. The bench samples at the falling edge that ends the start pulse, then checks that done is low one cycle later. Within a poll, a read follows the previous one by gap + 3 cycles. The bench stamps every read with a cycle counter and compares the differences, so it never counts edges from the start pulse. Every other result takes a variable number of cycles. The bench waits for done at falling edges, then checks status and the complete logs of flash writes and reads against sequences computed from the block offset, block size and geometry.

// File: rtl/fss_pkg.sv
// Shared types and constants for the flash block sequencer.
package fss_pkg;
    typedef enum logic {OP_ERASE = 1'b0, OP_PROG = 1'b1} fss_op_e;

    localparam logic [1:0] ST_OK      = 2'd0;
    localparam logic [1:0] ST_TIMEOUT = 2'd1;
    localparam logic [1:0] ST_NODEV   = 2'd2;

    localparam logic [15:0] UNLOCK_DATA1 = 16'h00AA;
    localparam logic [15:0] UNLOCK_DATA2 = 16'h0055;
    localparam int          UNLOCK_WORD1 = 'h555;
    localparam int          UNLOCK_WORD2 = 'h2AA;
    localparam logic [15:0] ERASED_WORD  = 16'hFFFF;
endpackage

// File: rtl/fss_dev_geom.sv
// Device lookup and erase-step selection.
// Assumes: dev_code and the geometry inputs are stable while used.
module fss_dev_geom #(
    parameter int AW = 24,
    parameter int NDEV = 2,
    parameter logic [NDEV*16-1:0] DEV_CODES = {16'h22C4, 16'h2249},
    parameter logic [NDEV*AW-1:0] SUB_BASES = {24'h1F0000, 24'h000000}
) (
    input  logic [15:0]   dev_code,
    input  logic [AW-1:0] cur_addr,
    input  logic [AW-1:0] sub_mask,
    input  logic [AW-1:0] sect_size,
    input  logic [AW-1:0] sub_size,
    output logic          known,
    output logic [AW-1:0] step
);
    logic [NDEV-1:0] hit;
    logic [AW-1:0]   base;

    // One comparator per configured device
    for (genvar g = 0; g < NDEV; g++) begin : g_dev
        assign hit[g] = (dev_code == DEV_CODES[g*16 +: 16]);
    end

    // Pick the matching subsector base and the step size
    always_comb begin
        base = '0;
        for (int i = 0; i < NDEV; i++) begin
            if (hit[i]) base = SUB_BASES[i*AW +: AW];
        end
        known = |hit;
        step  = ((cur_addr & sub_mask) == base) ? sub_size : sect_size;
    end
endmodule

// File: rtl/fss_cmd_writer.sv
// Issues one unlock-prefixed command burst, one write per cycle.
// Assumes: op, tgt_addr and tgt_data are held stable during the burst.
module fss_cmd_writer
    import fss_pkg::*;
#(
    parameter int AW = 24,
    parameter logic [15:0] CMD_ERASE_SETUP = 16'h0080,
    parameter logic [15:0] CMD_SECT_ERASE  = 16'h0030,
    parameter logic [15:0] CMD_PROGRAM     = 16'h00A0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  fss_op_e       op,
    input  logic [AW-1:0] tgt_addr,
    input  logic [15:0]   tgt_data,
    output logic          we,
    output logic [AW-1:0] addr,
    output logic [15:0]   wdata,
    output logic          last
);
    localparam logic [AW-1:0] A_UNL1 = AW'(UNLOCK_WORD1 << 1);
    localparam logic [AW-1:0] A_UNL2 = AW'(UNLOCK_WORD2 << 1);

    logic       active;
    logic [2:0] idx;
    logic [2:0] final_idx;

    assign final_idx = (op == OP_ERASE) ? 3'd5 : 3'd3;
    assign we        = active;
    assign last      = active && (idx == final_idx);

    // Address and data for the current burst position
    always_comb begin
        addr  = A_UNL1;
        wdata = UNLOCK_DATA1;
        if (op == OP_ERASE) begin
            case (idx)
                3'd1, 3'd4: begin addr = A_UNL2; wdata = UNLOCK_DATA2; end
                3'd2:       begin addr = A_UNL1; wdata = CMD_ERASE_SETUP; end
                3'd5:       begin addr = tgt_addr; wdata = CMD_SECT_ERASE; end
                default:    begin addr = A_UNL1; wdata = UNLOCK_DATA1; end
            endcase
        end else begin
            case (idx)
                3'd1:    begin addr = A_UNL2; wdata = UNLOCK_DATA2; end
                3'd2:    begin addr = A_UNL1; wdata = CMD_PROGRAM; end
                3'd3:    begin addr = tgt_addr; wdata = tgt_data; end
                default: begin addr = A_UNL1; wdata = UNLOCK_DATA1; end
            endcase
        end
    end

    // Burst position counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
        end else if (go) begin
            active <= 1'b1;
            idx    <= '0;
        end else if (active) begin
            if (last) active <= 1'b0;
            else      idx    <= idx + 3'd1;
        end
    end
endmodule

// File: rtl/fss_poller.sv
// Bounded readback poll: wait gap cycles, read, compare, repeat.
// Assumes: read data returns the cycle after re; inputs stable while busy.
module fss_poller #(
    parameter int AW = 24,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [AW-1:0] tgt_addr,
    input  logic [15:0]   expect_word,
    input  logic [CW-1:0] gap,
    input  logic [CW-1:0] limit,
    output logic          re,
    output logic [AW-1:0] addr,
    input  logic [15:0]   rdata,
    output logic          done,
    output logic          timeout
);
    typedef enum logic [1:0] {PL_IDLE, PL_WAIT, PL_READ, PL_CHECK} pl_state_e;

    pl_state_e     state;
    logic [CW-1:0] dcnt;
    logic [CW-1:0] reads;
    logic [CW:0]   reads_nx;
    logic          match;
    logic          spent;

    assign reads_nx = {1'b0, reads} + 1'b1;
    assign match    = (rdata == expect_word);
    assign spent    = (reads_nx >= {1'b0, limit});
    assign re       = (state == PL_READ);
    assign addr     = tgt_addr;
    assign done     = (state == PL_CHECK) && (match || spent);
    assign timeout  = (state == PL_CHECK) && !match && spent;

    // Poll state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PL_IDLE;
            dcnt  <= '0;
            reads <= '0;
        end else begin
            case (state)
                PL_IDLE: if (go) begin
                    state <= PL_WAIT;
                    dcnt  <= gap;
                    reads <= '0;
                end
                PL_WAIT: begin
                    if (dcnt == '0) state <= PL_READ;
                    else            dcnt  <= dcnt - 1'b1;
                end
                PL_READ: state <= PL_CHECK;
                PL_CHECK: begin
                    if (match || spent) begin
                        state <= PL_IDLE;
                    end else begin
                        state <= PL_WAIT;
                        dcnt  <= gap;
                        reads <= reads_nx[CW-1:0];
                    end
                end
                default: state <= PL_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fss_flash_seq.sv
// Top: erases the sectors under a block, then programs it word by word.
// Assumes: geometry, gap and limit ports are stable during an operation;
// blk_off + blk_size fits in AW bits; start is ignored unless idle.
module fss_flash_seq
    import fss_pkg::*;
#(
    parameter int AW = 24,
    parameter int CW = 16,
    parameter int NDEV = 2,
    parameter logic [NDEV*16-1:0] DEV_CODES = {16'h22C4, 16'h2249},
    parameter logic [NDEV*AW-1:0] SUB_BASES = {24'h1F0000, 24'h000000},
    parameter logic [15:0] CMD_ERASE_SETUP = 16'h0080,
    parameter logic [15:0] CMD_SECT_ERASE  = 16'h0030,
    parameter logic [15:0] CMD_PROGRAM     = 16'h00A0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] blk_off,
    input  logic [AW-1:0] blk_size,
    input  logic [15:0]   dev_code,
    input  logic [AW-1:0] sect_size,
    input  logic [AW-1:0] sub_size,
    input  logic [AW-1:0] sub_mask,
    input  logic [CW-1:0] erase_gap,
    input  logic [CW-1:0] erase_limit,
    input  logic [CW-1:0] prog_gap,
    input  logic [CW-1:0] prog_limit,
    output logic          buf_rd,
    output logic [AW-2:0] buf_addr,
    input  logic [15:0]   buf_rdata,
    output logic [AW-1:0] fl_addr,
    output logic [15:0]   fl_wdata,
    output logic          fl_we,
    output logic          fl_re,
    input  logic [15:0]   fl_rdata,
    output logic          done,
    output logic [1:0]    status
);
    typedef enum logic [2:0] {
        S_IDLE, S_ERASE, S_FETCH, S_LATCH, S_PROG, S_FIN
    } seq_state_e;

    seq_state_e    state;
    fss_op_e       op_q;
    logic [AW-1:0] cur;
    logic [AW-1:0] base_q;
    logic [AW:0]   end_q;
    logic [15:0]   dev_q;
    logic [15:0]   wdata_q;
    logic [1:0]    status_q;
    logic          cmd_go;

    logic          known;
    logic [AW-1:0] step;
    logic [AW:0]   next_sect;
    logic [AW:0]   next_word;
    logic [AW-1:0] word_off;
    logic [15:0]   dev_sel;

    logic          wr_we, wr_last;
    logic [AW-1:0] wr_addr;
    logic [15:0]   wr_data;
    logic          pl_re, pl_done, pl_to;
    logic [AW-1:0] pl_addr;

    assign dev_sel   = (state == S_IDLE) ? dev_code : dev_q;
    assign next_sect = {1'b0, cur} + {1'b0, step};
    assign next_word = {1'b0, cur} + {{AW-1{1'b0}}, 2'd2};
    assign word_off  = cur - base_q;
    assign buf_addr  = word_off[AW-1:1];
    assign buf_rd    = (state == S_FETCH);
    assign done      = (state == S_FIN);
    assign status    = status_q;

    fss_dev_geom #(
        .AW(AW), .NDEV(NDEV), .DEV_CODES(DEV_CODES), .SUB_BASES(SUB_BASES)
    ) u_geom (
        .dev_code (dev_sel),
        .cur_addr (cur),
        .sub_mask (sub_mask),
        .sect_size(sect_size),
        .sub_size (sub_size),
        .known    (known),
        .step     (step)
    );

    fss_cmd_writer #(
        .AW(AW), .CMD_ERASE_SETUP(CMD_ERASE_SETUP),
        .CMD_SECT_ERASE(CMD_SECT_ERASE), .CMD_PROGRAM(CMD_PROGRAM)
    ) u_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (cmd_go),
        .op      (op_q),
        .tgt_addr(cur),
        .tgt_data(wdata_q),
        .we      (wr_we),
        .addr    (wr_addr),
        .wdata   (wr_data),
        .last    (wr_last)
    );

    fss_poller #(.AW(AW), .CW(CW)) u_poll (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (wr_last),
        .tgt_addr   (cur),
        .expect_word((op_q == OP_ERASE) ? ERASED_WORD : wdata_q),
        .gap        ((op_q == OP_ERASE) ? erase_gap : prog_gap),
        .limit      ((op_q == OP_ERASE) ? erase_limit : prog_limit),
        .re         (pl_re),
        .addr       (pl_addr),
        .rdata      (fl_rdata),
        .done       (pl_done),
        .timeout    (pl_to)
    );

    // Flash bus: writer owns it during a burst, poller otherwise
    always_comb begin
        fl_we    = wr_we;
        fl_re    = pl_re;
        fl_wdata = wr_data;
        fl_addr  = wr_we ? wr_addr : pl_addr;
    end

    // Operation sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            op_q     <= OP_ERASE;
            cur      <= '0;
            base_q   <= '0;
            end_q    <= '0;
            dev_q    <= '0;
            wdata_q  <= '0;
            status_q <= ST_OK;
            cmd_go   <= 1'b0;
        end else begin
            cmd_go <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    op_q   <= OP_ERASE;
                    cur    <= blk_off;
                    base_q <= blk_off;
                    end_q  <= {1'b0, blk_off} + {1'b0, blk_size};
                    dev_q  <= dev_code;
                    if (!known) begin
                        status_q <= ST_NODEV;
                        state    <= S_FIN;
                    end else if (blk_size == '0) begin
                        status_q <= ST_OK;
                        state    <= S_FIN;
                    end else begin
                        cmd_go <= 1'b1;
                        state  <= S_ERASE;
                    end
                end
                S_ERASE: if (pl_done) begin
                    if (pl_to) begin
                        status_q <= ST_TIMEOUT;
                        state    <= S_FIN;
                    end else if (next_sect >= end_q) begin
                        op_q  <= OP_PROG;
                        cur   <= base_q;
                        state <= S_FETCH;
                    end else begin
                        cur    <= next_sect[AW-1:0];
                        cmd_go <= 1'b1;
                    end
                end
                S_FETCH: state <= S_LATCH;
                S_LATCH: begin
                    wdata_q <= buf_rdata;
                    cmd_go  <= 1'b1;
                    state   <= S_PROG;
                end
                S_PROG: if (pl_done) begin
                    if (pl_to) begin
                        status_q <= ST_TIMEOUT;
                        state    <= S_FIN;
                    end else if (next_word >= end_q) begin
                        status_q <= ST_OK;
                        state    <= S_FIN;
                    end else begin
                        cur   <= next_word[AW-1:0];
                        state <= S_FETCH;
                    end
                end
                S_FIN:   state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fss_flash_seq_chk.sv
// Port-level protocol checks for fss_flash_seq, attached by bind.
module fss_flash_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       done,
    input logic [1:0] status,
    input logic       fl_we,
    input logic       fl_re,
    input logic       buf_rd
);
    // R3/R7: writes and reads never share a cycle
    a_r3_bus_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_we && fl_re));
    // R6: poll reads are always separated by at least one idle cycle
    a_r6_read_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        fl_re |=> !fl_re);
    // R9: done lasts one cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: the bus is quiet while done is reported
    a_r9_quiet_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!fl_we && !fl_re));
    // R2: reported status is one of the three defined codes
    a_r2_status_code: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status != 2'd3));
    // R7: the buffer data cycle carries no flash write
    a_r7_buf_then_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd |=> !fl_we);
endmodule

bind fss_flash_seq fss_flash_seq_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .done  (done),
    .status(status),
    .fl_we (fl_we),
    .fl_re (fl_re),
    .buf_rd(buf_rd)
);

// File: tb/fss_flash_seq_test.sv
// Directed bench for fss_flash_seq with a behavioural flash and buffer.
module fss_flash_seq_test;
    localparam int AW = 24;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] blk_off = '0, blk_size = '0;
    logic [15:0]   dev_code = 16'h2249;
    logic [AW-1:0] sect_size = 24'h20, sub_size = 24'h08, sub_mask = 24'hFFFFE0;
    logic [CW-1:0] erase_gap = 16'd3, erase_limit = 16'd5;
    logic [CW-1:0] prog_gap = 16'd1, prog_limit = 16'd4;
    logic          buf_rd;
    logic [AW-2:0] buf_addr;
    logic [15:0]   buf_rdata = '0;
    logic [AW-1:0] fl_addr;
    logic [15:0]   fl_wdata;
    logic          fl_we, fl_re;
    logic [15:0]   fl_rdata = '0;
    logic          done;
    logic [1:0]    status;

    always #10 clk = ~clk;

    fss_flash_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_off(blk_off),
        .blk_size(blk_size), .dev_code(dev_code), .sect_size(sect_size),
        .sub_size(sub_size), .sub_mask(sub_mask), .erase_gap(erase_gap),
        .erase_limit(erase_limit), .prog_gap(prog_gap), .prog_limit(prog_limit),
        .buf_rd(buf_rd), .buf_addr(buf_addr), .buf_rdata(buf_rdata),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
        .fl_rdata(fl_rdata), .done(done), .status(status)
    );

    // Flash and buffer models with write/read logs
    logic [AW-1:0] wa [1024];
    logic [15:0]   wd [1024];
    logic [AW-1:0] ra [512];
    int            rc [512];
    int            nw = 0, nr = 0, cyc = 0, mode = 0, remain = 0;
    logic          prev_a0 = 1'b0, clr = 1'b0;
    logic          stuck_erase = 1'b0, stuck_prog = 1'b0;
    logic [15:0]   pdata = '0;

    function automatic logic [15:0] pat(input int i);
        return 16'h5A00 ^ 16'(i * 311);
    endfunction

    // Model: logs bus traffic and answers polls
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (buf_rd) buf_rdata <= pat(int'(buf_addr));
        if (clr) begin
            nw <= 0; nr <= 0; mode <= 0; prev_a0 <= 1'b0;
        end else begin
            if (fl_we) begin
                if (nw < 1024) begin wa[nw] <= fl_addr; wd[nw] <= fl_wdata; end
                nw <= nw + 1;
                prev_a0 <= (fl_addr == 24'hAAA) && (fl_wdata == 16'h00A0);
                if (prev_a0) begin
                    mode <= 2; pdata <= fl_wdata; remain <= 1;
                end else if (fl_wdata == 16'h0030 && fl_addr != 24'hAAA) begin
                    mode <= 1; remain <= 2;
                end
            end
            if (fl_re) begin
                if (nr < 512) begin ra[nr] <= fl_addr; rc[nr] <= cyc; end
                nr <= nr + 1;
                remain <= remain - 1;
                if (mode == 1) fl_rdata <= (stuck_erase || remain > 0) ? 16'h0000 : 16'hFFFF;
                else           fl_rdata <= (stuck_prog || remain > 0) ? ~pdata : pdata;
            end
        end
    end

    int n_checks = 0, n_fail = 0;
    logic [AW-1:0] ea [1024];
    logic [15:0]   ed [1024];
    int            ne;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [AW-1:0] a, input logic [15:0] d);
        ea[ne] = a; ed[ne] = d; ne++;
    endtask

    // Expected write list from the requirements (R3, R4, R7)
    task automatic build_exp(input int off, input int size, input logic [AW-1:0] sbase,
                             input int erase_only_sectors);
        int a;
        int ns;
        ne = 0; a = off; ns = 0;
        while (a < off + size && (erase_only_sectors == 0 || ns < erase_only_sectors)) begin
            push(24'hAAA, 16'hAA); push(24'h554, 16'h55); push(24'hAAA, 16'h80);
            push(24'hAAA, 16'hAA); push(24'h554, 16'h55); push(a[AW-1:0], 16'h30);
            ns++;
            a += (((a & int'(sub_mask)) == int'(sbase)) ? int'(sub_size) : int'(sect_size));
        end
        if (erase_only_sectors == 0) begin
            for (int w = off; w < off + size; w += 2) begin
                push(24'hAAA, 16'hAA); push(24'h554, 16'h55); push(24'hAAA, 16'hA0);
                push(w[AW-1:0], pat((w - off) / 2));
            end
        end
    endtask

    task automatic cmp_writes(input string tag, input int upto);
        int bad;
        bad = -1;
        for (int i = 0; i < upto; i++)
            if (bad < 0 && (wa[i] != ea[i] || wd[i] != ed[i])) bad = i;
        if (bad >= 0) chk(0, tag, int'(wd[bad]), int'(ed[bad]));
        else          chk(1, tag, 0, 0);
    endtask

    task automatic launch(input int off, input int size, input logic [15:0] dev);
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
        blk_off = off[AW-1:0]; blk_size = size[AW-1:0]; dev_code = dev;
        start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n;
        n = 0;
        while (!done && n < 20000) begin @(negedge clk); n++; end
        chk(done, {tag, " done seen"}, int'(done), 1);
    endtask

    task automatic t_reset;
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(status == 2'd0, "R1 status", int'(status), 0);
        chk(!fl_we && !fl_re, "R1 strobes", int'({fl_we, fl_re}), 0);
    endtask

    task automatic t_unknown;
        launch('h40, 'h40, 16'h1234);
        chk(done == 1'b1, "R2 done next cycle", int'(done), 1);
        chk(status == 2'd2, "R2 status", int'(status), 2);
        @(negedge clk);
        chk(done == 1'b0, "R9 one-cycle done", int'(done), 0);
        chk(nw == 0, "R2 no writes", nw, 0);
    endtask

    task automatic t_normal;
        launch('h40, 'h40, 16'h2249);
        wait_done("R9 normal");
        chk(status == 2'd0, "R9 success status", int'(status), 0);
        build_exp('h40, 'h40, 24'h0, 0);
        chk(nw == ne, "R4 write count", nw, ne);
        cmp_writes("R3 R7 write sequence", ne);
        chk(ra[0] == 24'h40 && ra[2] == 24'h40 && nr == 70, "R5 erase polls", nr, 70);
        chk(rc[1] - rc[0] == int'(erase_gap) + 3, "R6 erase spacing", rc[1] - rc[0],
            int'(erase_gap) + 3);
        chk(rc[7] - rc[6] == int'(prog_gap) + 3, "R6 program spacing", rc[7] - rc[6],
            int'(prog_gap) + 3);
        chk(ra[6] == 24'h40 && ra[8] == 24'h42, "R8 program poll address", int'(ra[8]), 'h42);
    endtask

    task automatic t_subsector;
        launch('h0, 'h20, 16'h2249);
        wait_done("R4 sub");
        build_exp('h0, 'h20, 24'h0, 0);
        chk(nw == ne && ne == 4 * 6 + 16 * 4, "R4 subsector count", nw, 4 * 6 + 16 * 4);
        cmp_writes("R4 subsector steps", ne);
        launch('h0, 'h20, 16'h22C4);
        wait_done("R4 other device");
        build_exp('h0, 'h20, 24'h1F0000, 0);
        chk(nw == ne && ne == 6 + 16 * 4, "R4 full sector count", nw, 6 + 16 * 4);
        cmp_writes("R4 full sector step", ne);
    endtask

    task automatic t_erase_timeout;
        stuck_erase = 1'b1;
        launch('h40, 'h40, 16'h2249);
        wait_done("R5 timeout");
        chk(status == 2'd1, "R5 timeout status", int'(status), 1);
        chk(nr == int'(erase_limit), "R5 read bound", nr, int'(erase_limit));
        chk(nw == 6, "R5 no program after timeout", nw, 6);
        stuck_erase = 1'b0;
    endtask

    task automatic t_prog_timeout;
        stuck_prog = 1'b1;
        launch('h40, 'h40, 16'h2249);
        wait_done("R8 timeout");
        chk(status == 2'd1, "R8 timeout status", int'(status), 1);
        chk(nw == 2 * 6 + 4, "R8 stops at once", nw, 16);
        chk(nr == 6 + int'(prog_limit), "R8 read bound", nr, 6 + int'(prog_limit));
        stuck_prog = 1'b0;
    endtask

    task automatic t_zero;
        launch('h40, 'h0, 16'h2249);
        chk(done == 1'b1 && status == 2'd0, "R9 zero size", int'(status), 0);
        @(negedge clk);
        chk(nw == 0 && nr == 0, "R9 zero size no access", nw + nr, 0);
    endtask

    task automatic t_busy;
        launch('h40, 'h40, 16'h2249);
        repeat (30) @(negedge clk);
        blk_off = '0; dev_code = 16'h1234; start = 1'b1;
        @(negedge clk) start = 1'b0;
        wait_done("R10 busy");
        chk(status == 2'd0, "R10 status unaffected", int'(status), 0);
        build_exp('h40, 'h40, 24'h0, 0);
        chk(nw == ne, "R10 write count", nw, ne);
        cmp_writes("R10 sequence unaffected", ne);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_unknown();
        t_normal();
        t_subsector();
        t_erase_timeout();
        t_prog_timeout();
        t_zero();
        t_busy();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule